// File: doc/BRIEF.md
# No-Turnaround Pipelined SRAM

This block is a synchronous static memory that keeps its data bus busy on every clock, even when reads and writes alternate. A read returns its word one clock after the clock that accepts the command. A write takes its data two clocks after its command. Because of this split, a write command can follow a read command on the next clock with no idle cycle, and a read can follow a write the same way.

A built-in 2-bit burst counter steps through four words. It can count in linear order (start plus beat) or in XOR order (start XOR beat). A stall input freezes every register. A nap input puts the memory to sleep and later wakes it, with two clocks of latency in each direction. A read of a word whose write data is still in flight returns that pending data, merged byte by byte.

The storage is a small parameterised register array held inside the block. This lets a testbench run it without any outside memory model.

Top module: `nts_sram`

## Requirements
- R1: On an active clock with `burst_cont`=0, a new command starts only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. `wr_n`=1 starts a read and `wr_n`=0 starts a write. If any of the three selects is inactive, the clock is a deselect and no read data is driven for it.
- R2: Read data for a command accepted on clock k is on `rdata` after clock k+1 and not earlier. `rd_drive` is 1 only for read data and only while `out_en_n`=0, and it follows `out_en_n` without waiting for a clock. While `rd_drive` is 0, `rdata` is zero.
- R3: Write data is sampled on the second active clock after the write command. `byte_en_n` is active low, one bit per byte with bit b covering `rdata[8b+7:8b]`, and is sampled with the command. With all bits at 1 the write is aborted and the array does not change.
- R4: Reads and writes can be issued on consecutive clocks in any mix with no idle clock, and each read returns the correct word. A clock that carries a write or a deselect yields `rd_drive`=0 one clock later.
- R5: A read of a word whose write command came one active clock earlier returns the data arriving on that clock. The merge is byte by byte: enabled bytes come from `wdata`, the rest come from the stored word.
- R6: While `stall`=1, every other synchronous input is ignored. No register changes, including the read output register and the pending write.
- R7: `burst_cont`=1 after a read or write continues it at the next burst address. With `order_xor`=0 the low two address bits are (start + beat) mod 4. After four beats the address wraps to the start value.
- R8: With `order_xor`=1 the low two address bits are start XOR beat.
- R9: `burst_cont`=1 after a deselect keeps the memory deselected, whatever the selects and `wr_n` are.
- R10: When `nap` goes to 1, the memory is asleep from the second clock on. While asleep, `rd_drive` is 0, all other inputs are ignored and the array keeps its contents. It is awake again on the second clock after `nap` returns to 0.
- R11: A synchronous `rst` clears all pending reads and writes, sets `rd_drive` to 0 and leaves the memory deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | 1 freezes the block for this clock |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_cont | input | 1 | 0 loads a new command; 1 continues the burst |
| wr_n | input | 1 | 0 write, 1 read (sampled with a new command) |
| byte_en_n | input | NBYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data, two active clocks after the command |
| out_en_n | input | 1 | Output enable, active low, combinational |
| order_xor | input | 1 | Burst order: 0 linear, 1 XOR |
| nap | input | 1 | Sleep request, active high |
| rdata | output | DATA_W | Read data, zero when not driven |
| rd_drive | output | 1 | Read data valid and driven |

## Verification
Single writes and reads separate the one-clock read latency from the two-clock write data latency, because the bench puts wrong data on `wdata` one clock early. A write followed at once by a read of the same word, with a sparse byte mask, exercises forwarding. An alternating write/read/write/read pattern shows that no idle cycles are needed. Bursts that start in the middle of a four-word group, run in both orders and run a fifth beat show the difference between linear and XOR stepping and the wrap to the start. Stall, nap and deselect sequences each carry a command that would have changed memory or output, and the bench then checks that nothing changed.

// File: rtl/nts_pkg.sv
package nts_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits of burst beat `beat` from `start`.
  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       xor_order);
    logic [1:0] lin;
    lin = start + beat;
    return xor_order ? (start ^ beat) : lin;
  endfunction

endpackage

// File: rtl/nts_cmd_decode.sv
module nts_cmd_decode #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              burst_cont,
  input  logic              sel_ok,
  input  logic              wr_n,
  input  logic              order_xor,
  input  logic [NBYTES-1:0] byte_en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              issue_rd,
  output logic              issue_wr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [NBYTES-1:0] cur_be
);
  import nts_pkg::*;

  op_e               op_q, op_n;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q, beat_n;
  logic              new_load;

  assign new_load = !burst_cont && sel_ok;
  assign beat_n   = beat_q + 2'd1;

  always_comb begin
    op_n = op_q;
    if (!burst_cont) begin
      if (sel_ok) op_n = wr_n ? OP_READ : OP_WRITE;
      else        op_n = OP_IDLE;
    end
  end

  assign cur_addr = new_load ? addr
                  : {base_q[ADDR_W-1:2], burst_lsb(base_q[1:0], beat_n, order_xor)};
  assign cur_be   = ~byte_en_n;
  assign issue_rd = active && (op_n == OP_READ);
  assign issue_wr = active && (op_n == OP_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      beat_q <= '0;
    end else if (active) begin
      op_q <= op_n;
      if (new_load) begin
        base_q <= addr;
        beat_q <= '0;
      end else if (burst_cont) begin
        beat_q <= beat_n;
      end
    end
  end

endmodule

// File: rtl/nts_wr_pipe.sv
module nts_wr_pipe #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              issue_wr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [NBYTES-1:0] cur_be,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [NBYTES-1:0] commit_be
);
  logic              s1_v, s2_v;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [NBYTES-1:0] s1_be, s2_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      s1_a  <= '0;
      s2_a  <= '0;
      s1_be <= '0;
      s2_be <= '0;
    end else if (active) begin
      s1_v  <= issue_wr;
      s1_a  <= cur_addr;
      s1_be <= cur_be;
      s2_v  <= s1_v;
      s2_a  <= s1_a;
      s2_be <= s1_be;
    end
  end

  assign commit_en   = active && s2_v;
  assign commit_addr = s2_a;
  assign commit_be   = s2_be;

endmodule

// File: rtl/nts_array.sv
module nts_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_be,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = NBYTES * BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBYTES; b++) begin
      if (wr_en && wr_be[b])
        mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nts_sleep_seq.sv
module nts_sleep_seq (
  input  logic clk,
  input  logic rst,
  input  logic nap,
  output logic asleep
);
  logic nap_q1, nap_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      nap_q1 <= 1'b0;
      nap_q2 <= 1'b0;
    end else begin
      nap_q1 <= nap;
      nap_q2 <= nap_q1;
    end
  end

  assign asleep = nap_q2;

endmodule

// File: rtl/nts_sram.sv
module nts_sram #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stall,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     burst_cont,
  input  logic                     wr_n,
  input  logic [NBYTES-1:0]        byte_en_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic                     out_en_n,
  input  logic                     order_xor,
  input  logic                     nap,
  output logic [NBYTES*BYTE_W-1:0] rdata,
  output logic                     rd_drive
);
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              asleep, active, sel_ok;
  logic              issue_rd, issue_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [NBYTES-1:0] cur_be;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [NBYTES-1:0] commit_be;
  logic              rd1_v, rq_v, fwd_hit;
  logic [ADDR_W-1:0] rd1_a;
  logic [DATA_W-1:0] arr_word, read_word, rq_d;

  assign active = !stall && !asleep;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  nts_sleep_seq u_sleep (
    .clk(clk), .rst(rst), .nap(nap), .asleep(asleep)
  );

  nts_cmd_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_dec (
    .clk(clk), .rst(rst), .active(active), .burst_cont(burst_cont),
    .sel_ok(sel_ok), .wr_n(wr_n), .order_xor(order_xor),
    .byte_en_n(byte_en_n), .addr(addr),
    .issue_rd(issue_rd), .issue_wr(issue_wr),
    .cur_addr(cur_addr), .cur_be(cur_be)
  );

  nts_wr_pipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_wpipe (
    .clk(clk), .rst(rst), .active(active), .issue_wr(issue_wr),
    .cur_addr(cur_addr), .cur_be(cur_be),
    .commit_en(commit_en), .commit_addr(commit_addr), .commit_be(commit_be)
  );

  nts_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk(clk), .wr_en(commit_en), .wr_addr(commit_addr), .wr_be(commit_be),
    .wr_data(wdata), .rd_addr(rd1_a), .rd_data(arr_word)
  );

  // Read stage 1: address accepted; array read happens during this cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd1_v <= 1'b0;
      rd1_a <= '0;
    end else if (active) begin
      rd1_v <= issue_rd;
      rd1_a <= cur_addr;
    end
  end

  // Write landing on this clock may target the word being read out.
  assign fwd_hit = commit_en && (commit_addr == rd1_a);

  for (genvar b = 0; b < NBYTES; b++) begin : g_merge
    assign read_word[b*BYTE_W +: BYTE_W] = (fwd_hit && commit_be[b])
                                         ? wdata[b*BYTE_W +: BYTE_W]
                                         : arr_word[b*BYTE_W +: BYTE_W];
  end

  // Output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      rq_v <= 1'b0;
      rq_d <= '0;
    end else if (active) begin
      rq_v <= rd1_v;
      rq_d <= read_word;
    end
  end

  assign rd_drive = rq_v && !out_en_n && !asleep;
  assign rdata    = rd_drive ? rq_d : '0;

endmodule

// File: rtl/nts_sram_chk.sv
module nts_sram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              out_en_n,
  input logic              nap,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_drive,
  input logic              active,
  input logic              asleep,
  input logic              issue_rd,
  input logic              issue_wr,
  input logic              rd1_v,
  input logic              rq_v,
  input logic [DATA_W-1:0] rq_d,
  input logic              commit_en
);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(issue_rd && issue_wr)); // R1

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    rd_drive |-> !out_en_n); // R2

  AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_drive |-> (rdata == '0)); // R2

  AST_NONREAD_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (active && !rd1_v) |=> !rd_drive); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(rq_d) && $stable(rq_v) && $stable(rd1_v))); // R6

  AST_STALL_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    stall |-> !commit_en); // R6

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (!rd_drive && !commit_en)); // R10

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (nap && $past(nap) && !$past(rst)) |=> asleep); // R10

  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!nap && !$past(nap) && !$past(rst)) |=> !asleep); // R10

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!rq_v && !rd1_v && !commit_en)); // R11

endmodule

bind nts_sram nts_sram_chk #(.DATA_W(NBYTES*BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .out_en_n(out_en_n), .nap(nap),
  .rdata(rdata), .rd_drive(rd_drive), .active(active), .asleep(asleep),
  .issue_rd(issue_rd), .issue_wr(issue_wr), .rd1_v(rd1_v), .rq_v(rq_v),
  .rq_d(rq_d), .commit_en(commit_en)
);

// File: tb/nts_sram_bench.sv
module nts_sram_bench;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst, stall, sel_a_n, sel_b, sel_c_n, burst_cont, wr_n;
  logic [NB-1:0] byte_en_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          out_en_n, order_xor, nap, rd_drive;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [DW-1:0] X1 = 32'h5A5A_0005;

  always #(CLK_P/2) clk = ~clk;

  nts_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(8)) u_nts_sram (
    .clk(clk), .rst(rst), .stall(stall), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .burst_cont(burst_cont), .wr_n(wr_n),
    .byte_en_n(byte_en_n), .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
    .order_xor(order_xor), .nap(nap), .rdata(rdata), .rd_drive(rd_drive)
  );

  function automatic logic [DW-1:0] dval(input logic [AW-1:0] a);
    return 32'hC0DE_0000 | DW'(a) * 32'h0001_0101;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic cont, input logic sel, input logic wr,
                     input logic [NB-1:0] ben, input logic [AW-1:0] a);
    burst_cont = cont; sel_a_n = !sel; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_n = wr; byte_en_n = ben; addr = a;
  endtask

  task automatic desel();
    put(1'b0, 1'b0, 1'b1, '1, '0);
  endtask

  task automatic wr_one(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] ben);
    put(1'b0, 1'b1, 1'b0, ben, a); wdata = ~d; tick();
    desel(); wdata = ~d; tick();
    wdata = d; tick();
    wdata = '0;
  endtask

  task automatic rd_one(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    put(1'b0, 1'b1, 1'b1, '1, a); tick();
    desel(); tick();
    chk({tag, " drive"}, DW'(rd_drive), 1);
    chk({tag, " data"}, rdata, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    chk("R11 reset drive", DW'(rd_drive), 0);
    chk("R11 reset data", rdata, 0);
  endtask

  task automatic t_single();
    wr_one(6'd5, X1, 4'b0000);
    put(1'b0, 1'b1, 1'b1, '1, 6'd5); tick();
    chk("R2 not before second edge", DW'(rd_drive), 0);
    desel(); tick();
    chk("R3 R2 read after write", rdata, X1);
    chk("R2 drive", DW'(rd_drive), 1);
    wr_one(6'd5, 32'hFFFF_FFFF, 4'b1111);
    rd_one("R3 abort keeps word", 6'd5, X1);
    wr_one(6'd7, 32'h1122_3344, 4'b0000);
    wr_one(6'd7, 32'hAABB_CCDD, 4'b0101);
    rd_one("R3 byte mask", 6'd7, 32'hAA22_CC44);
  endtask

  task automatic t_forward();
    wr_one(6'd3, 32'h1122_3344, 4'b0000);
    put(1'b0, 1'b1, 1'b0, 4'b1010, 6'd3); tick();
    put(1'b0, 1'b1, 1'b1, '1, 6'd3); tick();
    desel(); wdata = 32'hAABB_CCDD; tick(); wdata = '0;
    chk("R5 forwarded merge", rdata, 32'h11BB_33DD);
    desel(); tick();
    rd_one("R5 stored after forward", 6'd3, 32'h11BB_33DD);
  endtask

  task automatic t_alternate();
    put(1'b0, 1'b1, 1'b0, 4'b0000, 6'd12); tick();
    put(1'b0, 1'b1, 1'b1, '1, 6'd5); tick();
    put(1'b0, 1'b1, 1'b0, 4'b0000, 6'd13); wdata = dval(6'd12); tick();
    chk("R4 read between writes", rdata, X1);
    put(1'b0, 1'b1, 1'b1, '1, 6'd12); wdata = '0; tick();
    chk("R4 write cycle no drive", DW'(rd_drive), 0);
    put(1'b0, 1'b1, 1'b1, '1, 6'd13); wdata = dval(6'd13); tick();
    chk("R4 read A12", rdata, dval(6'd12));
    desel(); wdata = '0; tick();
    chk("R4 read A13", rdata, dval(6'd13));
    desel(); tick();
  endtask

  task automatic t_burst();
    logic [AW-1:0] lin_exp [5];
    logic [AW-1:0] xor_exp [4];
    lin_exp = '{6'd11, 6'd8, 6'd9, 6'd10, 6'd11};
    xor_exp = '{6'd10, 6'd11, 6'd8, 6'd9};
    order_xor = 1'b0;
    put(1'b0, 1'b1, 1'b0, 4'b0000, 6'd9); tick();
    put(1'b1, 1'b1, 1'b1, 4'b0000, 6'd0); tick();
    wdata = dval(6'd9); tick();
    wdata = dval(6'd10); tick();
    desel(); wdata = dval(6'd11); tick();
    wdata = dval(6'd8); tick();
    wdata = '0; tick();
    put(1'b0, 1'b1, 1'b1, '1, 6'd11); tick();
    for (int i = 0; i < 5; i++) begin
      if (i < 4) put(1'b1, 1'b1, 1'b1, '1, 6'd0); else desel();
      tick();
      chk($sformatf("R7 linear beat %0d", i), rdata, dval(lin_exp[i]));
    end
    tick();
    order_xor = 1'b1;
    put(1'b0, 1'b1, 1'b1, '1, 6'd10); tick();
    for (int i = 0; i < 4; i++) begin
      if (i < 3) put(1'b1, 1'b1, 1'b1, '1, 6'd0); else desel();
      tick();
      chk($sformatf("R8 xor beat %0d", i), rdata, dval(xor_exp[i]));
    end
    order_xor = 1'b0;
    tick();
  endtask

  task automatic t_select();
    put(1'b0, 1'b1, 1'b1, '1, 6'd5); sel_c_n = 1'b1; tick();
    desel(); tick();
    chk("R1 third select off", DW'(rd_drive), 0);
    put(1'b0, 1'b1, 1'b1, '1, 6'd5); sel_b = 1'b0; tick();
    put(1'b1, 1'b1, 1'b1, '1, 6'd5); tick();
    chk("R9 continue deselect 1", DW'(rd_drive), 0);
    tick();
    chk("R9 continue deselect 2", DW'(rd_drive), 0);
    desel(); tick(); tick();
  endtask

  task automatic t_oe();
    out_en_n = 1'b1;
    put(1'b0, 1'b1, 1'b1, '1, 6'd5); tick();
    desel(); tick();
    chk("R2 oe high no drive", DW'(rd_drive), 0);
    chk("R2 oe high data zero", rdata, 0);
    out_en_n = 1'b0; #1;
    chk("R2 oe low drives at once", rdata, X1);
    out_en_n = 1'b1; #1;
    chk("R2 oe high again", DW'(rd_drive), 0);
    out_en_n = 1'b0;
    tick();
  endtask

  task automatic t_stall();
    put(1'b0, 1'b1, 1'b1, '1, 6'd5); tick();
    stall = 1'b1; put(1'b0, 1'b1, 1'b0, 4'b0000, 6'd5); wdata = 32'hDEAD_BEEF;
    tick(); tick(); tick();
    chk("R6 stalled no output", DW'(rd_drive), 0);
    stall = 1'b0; desel(); wdata = '0; tick();
    chk("R6 read resumes", rdata, X1);
    stall = 1'b1; tick();
    chk("R6 output held", rdata, X1);
    stall = 1'b0; tick(); tick();
    rd_one("R6 ignored write", 6'd5, X1);
    put(1'b0, 1'b1, 1'b0, 4'b0000, 6'd6); tick();
    stall = 1'b1; desel(); wdata = 32'h0BAD_0BAD; tick();
    stall = 1'b0; tick();
    wdata = dval(6'd6); tick(); wdata = '0;
    rd_one("R6 write pipe held", 6'd6, dval(6'd6));
  endtask

  task automatic t_sleep();
    put(1'b0, 1'b1, 1'b1, '1, 6'd5); tick();
    desel(); tick();
    stall = 1'b1; nap = 1'b1; tick();
    chk("R10 awake after one edge", DW'(rd_drive), 1);
    tick();
    chk("R10 asleep after two edges", DW'(rd_drive), 0);
    stall = 1'b0; put(1'b0, 1'b1, 1'b0, 4'b0000, 6'd5); wdata = 32'h0;
    tick(); tick(); tick();
    chk("R10 quiet while asleep", DW'(rd_drive), 0);
    stall = 1'b1; desel(); nap = 1'b0; tick();
    chk("R10 still asleep one edge", DW'(rd_drive), 0);
    tick();
    chk("R10 awake after two edges", rdata, X1);
    stall = 1'b0; tick(); tick();
    rd_one("R10 contents kept", 6'd5, X1);
  endtask

  task automatic t_reset_mid();
    put(1'b0, 1'b1, 1'b1, '1, 6'd5); tick();
    rst = 1'b1; desel(); tick(); rst = 1'b0;
    chk("R11 reset drops read", DW'(rd_drive), 0);
    tick();
    chk("R11 deselected after reset", DW'(rd_drive), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    report();
    $finish;
  end

  initial begin
    rst = 1'b1; stall = 1'b0; nap = 1'b0; out_en_n = 1'b0; order_xor = 1'b0;
    wdata = '0;
    desel();
    @(negedge clk);
    t_reset();
    t_single();
    t_forward();
    t_alternate();
    t_burst();
    t_select();
    t_oe();
    t_stall();
    t_sleep();
    t_reset_mid();
    report();
    $finish;
  end

endmodule